// File: doc/BRIEF.md
# Decode Operand Bypass Selector

This block picks the two operand words that the decode stage of a five-stage pipelined processor hands to execute. Each operand is named by a 4-bit source register ID. When a younger result for that register is still moving through execute, memory or write-back, the block takes that result instead of the stale register-file word. Five results in flight can be bypassed: the ALU result in execute, the load data and the pending E-port result in memory, and the pending M-port and E-port results in write-back.

The first operand has one extra duty. For jump and call instructions, the later stages need the address of the next sequential instruction, and this block sends it down the first-operand path. That address replaces any bypassed or register value. The second operand has no such override. The block is purely combinational. The register file, the pipeline registers and the hazard/stall logic sit around it.

Top module: `decode_operand_sel`

## Requirements
- R1: When an operand's source ID equals the destination ID of exactly one in-flight result, the operand equals that result's value. The five results are execute E, memory M, memory E, write-back M and write-back E.
- R2: When several in-flight results match, the youngest wins, in this order: execute E, then memory M, then memory E, then write-back M, then write-back E.
- R3: When the decode instruction code is 0x7 (jump) or 0x8 (call), `opnd_a` equals `dec_next_pc`, whatever the IDs and values.
- R4: `opnd_b` is never replaced by `dec_next_pc`. With code 0x7 or 0x8 it still follows R1, R2 and R5.
- R5: When no in-flight result matches, `opnd_a` equals `rf_a_data` and `opnd_b` equals `rf_b_data`. R3 still applies to `opnd_a`.
- R6: ID 0xF means "no register" and never matches. A source ID of 0xF yields the register-file word even when destination IDs are also 0xF.
- R7: Outputs depend only on the present inputs. A change on any value input reaches the outputs in the same evaluation, with no clock and no held state.
- R8: Every ID from 0x0 to 0xE can be bypassed, including 0x4 (the stack pointer), on both operands at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_icode | input | 4 | Instruction code of the instruction in decode |
| dec_next_pc | input | 64 | Fall-through address of the decode instruction |
| src_a_id | input | 4 | Register ID for the first operand |
| src_b_id | input | 4 | Register ID for the second operand |
| rf_a_data | input | 64 | Register-file read word for the first operand |
| rf_b_data | input | 64 | Register-file read word for the second operand |
| ex_dst_e | input | 4 | Destination ID of the ALU result in execute |
| ex_val_e | input | 64 | ALU result in execute |
| mem_dst_m | input | 4 | Destination ID of the load data in memory |
| mem_val_m | input | 64 | Load data in memory |
| mem_dst_e | input | 4 | Destination ID of the E-port result in memory |
| mem_val_e | input | 64 | E-port result in memory |
| wb_dst_m | input | 4 | Destination ID of the M-port result in write-back |
| wb_val_m | input | 64 | M-port result in write-back |
| wb_dst_e | input | 4 | Destination ID of the E-port result in write-back |
| wb_val_e | input | 64 | E-port result in write-back |
| opnd_a | output | 64 | Selected first operand |
| opnd_b | output | 64 | Selected second operand |

## Verification
The block holds no state, so any fault shows at the ports as soon as the inputs settle. Possible faults are a wrong match decision, a swapped priority or a misplaced override. Each bypass value in the bench is a distinct word tied to its source, so a wrong pick names the source that was taken. Vectors that set several destinations to the same ID expose a priority swap at once. Vectors with IDs of 0xF on both sides expose a match that ignores the no-register code. Call, jump and return codes with live matches separate the first-operand override from the second operand's path.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_SRC = 5;
  localparam logic [3:0] CODE_JUMP = 4'h7;
  localparam logic [3:0] CODE_CALL = 4'h8;

  // Index order is the priority order: lower index = younger producer.
  typedef enum logic [2:0] {
    SRC_EX_E  = 3'd0,
    SRC_MEM_M = 3'd1,
    SRC_MEM_E = 3'd2,
    SRC_WB_M  = 3'd3,
    SRC_WB_E  = 3'd4
  } fwd_src_e;

  function automatic logic is_pc_pass(input logic [3:0] code);
    return (code == CODE_JUMP) || (code == CODE_CALL);
  endfunction
endpackage

// File: rtl/fwd_id_match.sv
module fwd_id_match #(
  parameter int ID_W    = 4,
  parameter int NUM_SRC = 5
) (
  input  logic [ID_W-1:0]              src_id,
  input  logic [NUM_SRC-1:0][ID_W-1:0] dst_ids,
  output logic [NUM_SRC-1:0]           hit
);
  localparam logic [ID_W-1:0] ID_NONE = {ID_W{1'b1}};

  logic src_live;
  assign src_live = (src_id != ID_NONE);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_cmp
    assign hit[k] = src_live && (dst_ids[k] != ID_NONE) && (dst_ids[k] == src_id);
  end
endmodule

// File: rtl/fwd_prio_pick.sv
module fwd_prio_pick #(
  parameter int DATA_W  = 64,
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0]             hit,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] fwd_vals,
  input  logic [DATA_W-1:0]              rf_val,
  output logic [DATA_W-1:0]              picked
);
  // Walk from oldest to youngest so the youngest hit is written last.
  always_comb begin
    picked = rf_val;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (hit[k]) picked = fwd_vals[k];
    end
  end
endmodule

// File: rtl/decode_operand_sel.sv
module decode_operand_sel
  import fwd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ID_W   = 4
) (
  input  logic [3:0]        dec_icode,
  input  logic [DATA_W-1:0] dec_next_pc,
  input  logic [ID_W-1:0]   src_a_id,
  input  logic [ID_W-1:0]   src_b_id,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic [ID_W-1:0]   ex_dst_e,
  input  logic [DATA_W-1:0] ex_val_e,
  input  logic [ID_W-1:0]   mem_dst_m,
  input  logic [DATA_W-1:0] mem_val_m,
  input  logic [ID_W-1:0]   mem_dst_e,
  input  logic [DATA_W-1:0] mem_val_e,
  input  logic [ID_W-1:0]   wb_dst_m,
  input  logic [DATA_W-1:0] wb_val_m,
  input  logic [ID_W-1:0]   wb_dst_e,
  input  logic [DATA_W-1:0] wb_val_e,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int LANES = 2;

  logic [NUM_SRC-1:0][ID_W-1:0]   dst_ids;
  logic [NUM_SRC-1:0][DATA_W-1:0] fwd_vals;

  assign dst_ids[SRC_EX_E]   = ex_dst_e;
  assign dst_ids[SRC_MEM_M]  = mem_dst_m;
  assign dst_ids[SRC_MEM_E]  = mem_dst_e;
  assign dst_ids[SRC_WB_M]   = wb_dst_m;
  assign dst_ids[SRC_WB_E]   = wb_dst_e;
  assign fwd_vals[SRC_EX_E]  = ex_val_e;
  assign fwd_vals[SRC_MEM_M] = mem_val_m;
  assign fwd_vals[SRC_MEM_E] = mem_val_e;
  assign fwd_vals[SRC_WB_M]  = wb_val_m;
  assign fwd_vals[SRC_WB_E]  = wb_val_e;

  logic [LANES-1:0][ID_W-1:0]   lane_src;
  logic [LANES-1:0][DATA_W-1:0] lane_rf;
  logic [LANES-1:0][DATA_W-1:0] lane_out;

  assign lane_src[0] = src_a_id;
  assign lane_src[1] = src_b_id;
  assign lane_rf[0]  = rf_a_data;
  assign lane_rf[1]  = rf_b_data;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [NUM_SRC-1:0] hit;
    logic [DATA_W-1:0]  bypassed;

    fwd_id_match #(.ID_W(ID_W), .NUM_SRC(NUM_SRC)) u_match (
      .src_id  (lane_src[l]),
      .dst_ids (dst_ids),
      .hit     (hit)
    );

    fwd_prio_pick #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_pick (
      .hit      (hit),
      .fwd_vals (fwd_vals),
      .rf_val   (lane_rf[l]),
      .picked   (bypassed)
    );

    if (l == 0) begin : g_pc_merge
      // R3: jump/call carry the fall-through address on this lane.
      assign lane_out[l] = is_pc_pass(dec_icode) ? dec_next_pc : bypassed;
    end else begin : g_plain
      assign lane_out[l] = bypassed;
    end
  end

  assign opnd_a = lane_out[0];
  assign opnd_b = lane_out[1];
endmodule

// File: rtl/fwd_sel_checker.sv
module fwd_sel_checker #(
  parameter int DATA_W = 64,
  parameter int ID_W   = 4
) (
  input logic [3:0]        dec_icode,
  input logic [DATA_W-1:0] dec_next_pc,
  input logic [ID_W-1:0]   src_a_id,
  input logic [ID_W-1:0]   src_b_id,
  input logic [DATA_W-1:0] rf_a_data,
  input logic [DATA_W-1:0] rf_b_data,
  input logic [ID_W-1:0]   ex_dst_e,
  input logic [DATA_W-1:0] ex_val_e,
  input logic [ID_W-1:0]   mem_dst_m,
  input logic [DATA_W-1:0] mem_val_m,
  input logic [ID_W-1:0]   mem_dst_e,
  input logic [DATA_W-1:0] mem_val_e,
  input logic [ID_W-1:0]   wb_dst_m,
  input logic [DATA_W-1:0] wb_val_m,
  input logic [ID_W-1:0]   wb_dst_e,
  input logic [DATA_W-1:0] wb_val_e,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);
  localparam logic [ID_W-1:0] NONE = {ID_W{1'b1}};

  logic pass_pc, b_none;
  assign pass_pc = (dec_icode == 4'h7) || (dec_icode == 4'h8);
  assign b_none  = (src_b_id == NONE) ||
                   ((src_b_id != ex_dst_e) && (src_b_id != mem_dst_m) &&
                    (src_b_id != mem_dst_e) && (src_b_id != wb_dst_m) &&
                    (src_b_id != wb_dst_e));

  always_comb begin
    if (pass_pc) AST_PC_ON_A: assert (opnd_a == dec_next_pc); // R3
    if (!pass_pc && src_a_id != NONE && src_a_id == ex_dst_e)
      AST_EX_WINS_A: assert (opnd_a == ex_val_e); // R2
    if (src_b_id != NONE && src_b_id == ex_dst_e)
      AST_EX_WINS_B: assert (opnd_b == ex_val_e); // R4
    if (!pass_pc && src_a_id == NONE)
      AST_NONE_ID_A: assert (opnd_a == rf_a_data); // R6
    if (b_none) AST_RF_FALLBACK_B: assert (opnd_b == rf_b_data); // R5
    AST_B_LEGAL_SRC: assert (opnd_b == rf_b_data || opnd_b == ex_val_e ||
                             opnd_b == mem_val_m || opnd_b == mem_val_e ||
                             opnd_b == wb_val_m  || opnd_b == wb_val_e); // R1
  end
endmodule

bind decode_operand_sel fwd_sel_checker #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .dec_icode(dec_icode), .dec_next_pc(dec_next_pc),
  .src_a_id(src_a_id), .src_b_id(src_b_id),
  .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
  .ex_dst_e(ex_dst_e), .ex_val_e(ex_val_e),
  .mem_dst_m(mem_dst_m), .mem_val_m(mem_val_m),
  .mem_dst_e(mem_dst_e), .mem_val_e(mem_val_e),
  .wb_dst_m(wb_dst_m), .wb_val_m(wb_val_m),
  .wb_dst_e(wb_dst_e), .wb_val_e(wb_val_e),
  .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/sim_decode_operand_sel.sv
module sim_decode_operand_sel;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int WATCHDOG = 1000;

  // selector codes: 0 exE, 1 memM, 2 memE, 3 wbM, 4 wbE, 5 regfile, 6 next pc
  typedef struct packed {
    logic [3:0] icode, sa, sb, de, dmm, dme, dwm, dwe;
    logic [2:0] ea, eb;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'h1, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 3'd5, 3'd5}, // R5
    '{4'h6, 4'h3, 4'h5, 4'h3, 4'hF, 4'hF, 4'hF, 4'hF, 3'd0, 3'd5}, // R1
    '{4'h6, 4'h2, 4'h2, 4'hF, 4'h2, 4'hF, 4'hF, 4'hF, 3'd1, 3'd1}, // R1
    '{4'h6, 4'h2, 4'h2, 4'hF, 4'hF, 4'h2, 4'hF, 4'hF, 3'd2, 3'd2}, // R1
    '{4'h6, 4'h2, 4'h2, 4'hF, 4'hF, 4'hF, 4'h2, 4'hF, 3'd3, 3'd3}, // R1
    '{4'h6, 4'h2, 4'h2, 4'hF, 4'hF, 4'hF, 4'hF, 4'h2, 3'd4, 3'd4}, // R1
    '{4'h6, 4'h6, 4'h6, 4'h6, 4'h6, 4'h6, 4'h6, 4'h6, 3'd0, 3'd0}, // R2
    '{4'h6, 4'h6, 4'h6, 4'hF, 4'h6, 4'h6, 4'h6, 4'h6, 3'd1, 3'd1}, // R2
    '{4'h6, 4'h6, 4'h6, 4'hF, 4'hF, 4'h6, 4'h6, 4'h6, 3'd2, 3'd2}, // R2
    '{4'h6, 4'h6, 4'h6, 4'hF, 4'hF, 4'hF, 4'h6, 4'h6, 3'd3, 3'd3}, // R2
    '{4'h8, 4'h4, 4'h4, 4'h4, 4'h4, 4'h4, 4'h4, 4'h4, 3'd6, 3'd0}, // R3 R4 R8
    '{4'h7, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 3'd6, 3'd5}, // R3
    '{4'h2, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 3'd5, 3'd5}, // R6
    '{4'h6, 4'h1, 4'h9, 4'h9, 4'hF, 4'hF, 4'h1, 4'hF, 3'd3, 3'd0}, // R1
    '{4'h9, 4'h4, 4'h4, 4'hF, 4'hF, 4'h4, 4'hF, 4'hF, 3'd2, 3'd2}, // R8
    '{4'h6, 4'hE, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hE, 3'd4, 3'd1}  // R8
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] dec_icode, src_a_id, src_b_id;
  logic [3:0] ex_dst_e, mem_dst_m, mem_dst_e, wb_dst_m, wb_dst_e;
  logic [DW-1:0] dec_next_pc, rf_a_data, rf_b_data;
  logic [DW-1:0] ex_val_e, mem_val_m, mem_val_e, wb_val_m, wb_val_e;
  logic [DW-1:0] opnd_a, opnd_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  decode_operand_sel u0 (
    .dec_icode(dec_icode), .dec_next_pc(dec_next_pc),
    .src_a_id(src_a_id), .src_b_id(src_b_id),
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
    .ex_dst_e(ex_dst_e), .ex_val_e(ex_val_e),
    .mem_dst_m(mem_dst_m), .mem_val_m(mem_val_m),
    .mem_dst_e(mem_dst_e), .mem_val_e(mem_val_e),
    .wb_dst_m(wb_dst_m), .wb_val_m(wb_val_m),
    .wb_dst_e(wb_dst_e), .wb_val_e(wb_val_e),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [DW-1:0] pick(input logic [2:0] sel, input bit lane_b);
    case (sel)
      3'd0: return ex_val_e;
      3'd1: return mem_val_m;
      3'd2: return mem_val_e;
      3'd3: return wb_val_m;
      3'd4: return wb_val_e;
      3'd5: return lane_b ? rf_b_data : rf_a_data;
      default: return dec_next_pc;
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    dec_icode = v.icode; src_a_id = v.sa; src_b_id = v.sb;
    ex_dst_e = v.de; mem_dst_m = v.dmm; mem_dst_e = v.dme;
    wb_dst_m = v.dwm; wb_dst_e = v.dwe;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    dec_next_pc = 64'h0000_0000_0000_1A2B;
    rf_a_data = 64'hAAAA_0000_0000_00AA;
    rf_b_data = 64'hBBBB_0000_0000_00BB;
    ex_val_e  = 64'hE0E0_0000_0000_0001;
    mem_val_m = 64'h3030_0000_0000_0002;
    mem_val_e = 64'h3E3E_0000_0000_0003;
    wb_val_m  = 64'h7070_0000_0000_0004;
    wb_val_e  = 64'h7E7E_0000_0000_0005;
    apply(VECS[0]);
    @(negedge clk); #1;
    check("R5 idle A", opnd_a, rf_a_data);
    check("R5 idle B", opnd_b, rf_b_data);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #1;
      check($sformatf("vec%0d opnd_a", i), opnd_a, pick(VECS[i].ea, 1'b0));
      check($sformatf("vec%0d opnd_b", i), opnd_b, pick(VECS[i].eb, 1'b1));
    end

    // R7: value change with no clock edge reaches the outputs at once
    @(negedge clk);
    apply('{4'h6, 4'h5, 4'h5, 4'h5, 4'hF, 4'hF, 4'hF, 4'hF, 3'd0, 3'd0});
    #1;
    ex_val_e = 64'h1234_5678_9ABC_DEF0;
    #1;
    check("R7 A follows", opnd_a, 64'h1234_5678_9ABC_DEF0);
    check("R7 B follows", opnd_b, 64'h1234_5678_9ABC_DEF0);
    rf_a_data = 64'h0F0F_0F0F_0F0F_0F0F;
    src_a_id = 4'h3;
    #1;
    check("R7 A to regfile", opnd_a, 64'h0F0F_0F0F_0F0F_0F0F);

    // R6: none-ID on source and on every destination
    @(negedge clk);
    apply('{4'h6, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 3'd5, 3'd5});
    #1;
    check("R6 A none", opnd_a, rf_a_data);
    check("R6 B none", opnd_b, rf_b_data);

    // R4: call code with B matching write-back M only
    @(negedge clk);
    apply('{4'h8, 4'hC, 4'hC, 4'hF, 4'hF, 4'hF, 4'hC, 4'hF, 3'd6, 3'd3});
    #1;
    check("R4 B no override", opnd_b, wb_val_m);
    check("R3 A override", opnd_a, dec_next_pc);

    done = 1;
    finish_run();
  end
endmodule